// File: doc/BRIEF.md
# Thresholded Performance Event Counter

This block is one performance-monitor counter. Every cycle it receives a small event increment (zero to fifteen events seen in that cycle) and decides how much of it to accumulate. When a non-zero threshold is programmed, the cycle's event value is compared with the threshold using one of four relations. If the relation fails, that cycle contributes nothing. If it holds, the counter adds either the raw event value or exactly one, depending on a count-by-one option. With a zero threshold, the comparison is bypassed and the raw value is always added.

Counting can be suppressed by privilege level. Each of levels 0, 1 and 2 has its own exclude bit. Level-2 activity is never counted while the guest indicator is high. The accumulator runs either as a 32-bit counter or as a 64-bit counter and wraps at its width. A simple write port loads it, and its value is always visible on a read port.

Configuration is written as one word. A write whose threshold exceeds the implemented maximum is refused: the configuration stays as it was and an error flag is raised. A non-zero threshold is also refused when thresholding is built out.

Top module: `thresh_evt_counter`

## Requirements
- R1: After reset the counter reads 0, the error flag is 0, and the configuration is all zero (threshold 0, relation 0, count-by-one off, 32-bit mode, no level excluded).
- R2: With threshold 0 the counter adds the raw event value every counted cycle, whatever the relation select and count-by-one settings are.
- R3: With a non-zero threshold, the relation select compares the event value E with the threshold T: code 0 means E != T, 1 means E == T, 2 means E >= T, 3 means E < T. A cycle whose relation fails adds 0.
- R4: When the relation holds and count-by-one is 0, the cycle's event value is added.
- R5: When the relation holds and count-by-one is 1, exactly 1 is added, whatever the event value.
- R6: Mode bit 0 gives a 32-bit counter that wraps modulo 2^32 and reads with bits 63:32 equal to zero. Mode bit 1 gives a 64-bit counter that wraps modulo 2^64.
- R7: Exclude-mask bit i (i = 0, 1, 2) stops all counting in cycles where the privilege level is i. The privilege level is 0, 1 or 2.
- R8: While the guest indicator is 1, cycles at privilege level 2 add nothing, even with a clear mask.
- R9: A configuration write whose threshold exceeds THR_MAX is rejected. So is any non-zero threshold when THR_EN is 0. A rejected write leaves every configuration field unchanged and sets the error flag. An accepted write applies all fields and clears the flag. The flag changes only on configuration writes.
- R10: A counter write loads the written value (the low 32 bits, zero-extended, in 32-bit mode). It takes priority over any increment in the same cycle.
- R11: An event presented in a cycle shows on the read port after that cycle's rising edge. A configuration written at an edge governs events from the following cycle onward. The event in the write cycle itself uses the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_thresh | input | 12 | Threshold value to write |
| cfg_rel | input | 2 | Relation select to write |
| cfg_by_one | input | 1 | Count-by-one option to write |
| cfg_wide | input | 1 | Width mode to write (0 = 32-bit, 1 = 64-bit) |
| cfg_excl | input | 3 | Privilege exclude mask to write |
| cfg_err | output | 1 | Last configuration write was rejected |
| evt_inc | input | 4 | Events observed this cycle |
| priv_lvl | input | 2 | Current privilege level (0 to 2) |
| in_guest | input | 1 | Core is running a guest |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 64 | Counter write value |
| cnt_rdata | output | 64 | Counter read value |

## Verification
The assertions take for granted that the privilege level never carries the unused code 3, and that every input is at a known value from the first clock after reset. The stimulus draws the privilege level only from 0, 1 and 2. It drives every input at the falling edge, and so keeps within both assumptions. Random configuration writes use thresholds that run past the implemented maximum, so refused writes appear among the accepted ones. Random thresholds are also kept small often enough that all four relations both pass and fail.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int THR_W = 12;
  localparam int NLVL  = 3;

  typedef enum logic [1:0] {
    REL_NE = 2'd0,
    REL_EQ = 2'd1,
    REL_GE = 2'd2,
    REL_LT = 2'd3
  } rel_e;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    rel_e             rel;
    logic             by_one;
    logic             wide;
    logic [NLVL-1:0]  excl;
  } cfg_t;
endpackage

// File: rtl/thr_cfg_reg.sv
module thr_cfg_reg
  import thr_pkg::*;
#(
  parameter int THR_MAX = 255,
  parameter bit THR_EN  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic we_i,
  input  cfg_t cfg_i,
  output cfg_t cfg_q,
  output logic err_q
);
  localparam logic [THR_W-1:0] MAX_L = THR_W'(THR_MAX);

  cfg_t cfg_d;
  logic err_d;
  logic ok;

  always_comb begin
    ok    = (cfg_i.thr == '0) || (THR_EN && (cfg_i.thr <= MAX_L));
    cfg_d = cfg_q;
    err_d = err_q;
    if (we_i) begin
      err_d = !ok;
      if (ok) cfg_d = cfg_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      err_q <= 1'b0;
    end else if (we_i) begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  // R9
  reject_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (cfg_i.thr > MAX_L)) |=> (cfg_q == $past(cfg_q)) && err_q);

  // R9
  err_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(err_q));
endmodule

// File: rtl/thr_qualify.sv
module thr_qualify
  import thr_pkg::*;
#(
  parameter int EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [THR_W-1:0] thr_i,
  input  rel_e             rel_i,
  input  logic             by_one_i,
  input  logic [EVT_W-1:0] evt_i,
  output logic [EVT_W-1:0] add_o
);
  logic [THR_W-1:0] evt_x;
  logic             pass;

  always_comb begin
    evt_x = THR_W'(evt_i);
    unique case (rel_i)
      REL_NE:  pass = (evt_x != thr_i);
      REL_EQ:  pass = (evt_x == thr_i);
      REL_GE:  pass = (evt_x >= thr_i);
      default: pass = (evt_x <  thr_i);
    endcase
    if (thr_i == '0)  add_o = evt_i;
    else if (!pass)   add_o = '0;
    else if (by_one_i) add_o = EVT_W'(1);
    else              add_o = evt_i;
  end

  // R5
  by_one_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (by_one_i && (thr_i != '0)) |-> (add_o <= EVT_W'(1)));

  // R3
  eq_miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr_i != '0) && (rel_i == REL_EQ) && (THR_W'(evt_i) != thr_i)) |-> (add_o == '0));

  // R2
  bypass_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_i == '0) |-> (add_o == evt_i));
endmodule

// File: rtl/thr_lvl_gate.sv
module thr_lvl_gate
  import thr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_i,
  input  logic            guest_i,
  input  logic [NLVL-1:0] excl_i,
  output logic            en_o
);
  logic [NLVL-1:0] hit;

  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    assign hit[i] = (priv_i == 2'(i)) && excl_i[i];
  end

  assign en_o = !(|hit) && !(guest_i && (priv_i == 2'd2));

  // R7
  priv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_i != 2'd3);

  // R8
  guest_l2_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guest_i && (priv_i == 2'd2)) |-> !en_o);
endmodule

// File: rtl/thr_accum.sv
module thr_accum #(
  parameter int CNT_W    = 64,
  parameter int NARROW_W = 32,
  parameter int EVT_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wide_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             en_i,
  input  logic [EVT_W-1:0] add_i,
  output logic [CNT_W-1:0] rdata_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             ld;

  always_comb begin
    ld = we_i || en_i;
    if (we_i)      cnt_d = wdata_i;
    else if (en_i) cnt_d = cnt_q + CNT_W'(add_i);
    else           cnt_d = cnt_q;
    if (!wide_i) cnt_d[CNT_W-1:NARROW_W] = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (ld) cnt_q <= cnt_d;
  end

  always_comb begin
    rdata_o = cnt_q;
    if (!wide_i) rdata_o[CNT_W-1:NARROW_W] = '0;
  end

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && wide_i) |=> (cnt_q == $past(wdata_i)));

  // R6
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wide_i && ld) |=> (cnt_q[CNT_W-1:NARROW_W] == '0));

  // R3
  no_add_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i && (!en_i || (add_i == '0))) |=> $stable(cnt_q[NARROW_W-1:0]));
endmodule

// File: rtl/thresh_evt_counter.sv
module thresh_evt_counter
  import thr_pkg::*;
#(
  parameter int THR_MAX = 255,
  parameter bit THR_EN  = 1'b1,
  parameter int EVT_W   = 4,
  parameter int CNT_W   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [11:0]      cfg_thresh,
  input  logic [1:0]       cfg_rel,
  input  logic             cfg_by_one,
  input  logic             cfg_wide,
  input  logic [2:0]       cfg_excl,
  output logic             cfg_err,
  input  logic [EVT_W-1:0] evt_inc,
  input  logic [1:0]       priv_lvl,
  input  logic             in_guest,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_rdata
);
  localparam int NARROW_W = CNT_W / 2;

  cfg_t             cfg_in;
  cfg_t             cfg;
  logic [EVT_W-1:0] add;
  logic             lvl_en;

  always_comb begin
    cfg_in.thr    = cfg_thresh;
    cfg_in.rel    = rel_e'(cfg_rel);
    cfg_in.by_one = cfg_by_one;
    cfg_in.wide   = cfg_wide;
    cfg_in.excl   = cfg_excl;
  end

  thr_cfg_reg #(.THR_MAX(THR_MAX), .THR_EN(THR_EN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .cfg_i(cfg_in),
    .cfg_q(cfg), .err_q(cfg_err)
  );

  thr_qualify #(.EVT_W(EVT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .thr_i(cfg.thr), .rel_i(cfg.rel),
    .by_one_i(cfg.by_one), .evt_i(evt_inc), .add_o(add)
  );

  thr_lvl_gate u_gate (
    .clk(clk), .rst_n(rst_n), .priv_i(priv_lvl), .guest_i(in_guest),
    .excl_i(cfg.excl), .en_o(lvl_en)
  );

  thr_accum #(.CNT_W(CNT_W), .NARROW_W(NARROW_W), .EVT_W(EVT_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .wide_i(cfg.wide), .we_i(cnt_we),
    .wdata_i(cnt_wdata), .en_i(lvl_en), .add_i(add), .rdata_o(cnt_rdata)
  );

  // R7
  excluded_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && (priv_lvl != 2'd3) && cfg.excl[priv_lvl]) |=> $stable(cnt_rdata[NARROW_W-1:0]));
endmodule

// File: tb/thresh_evt_counter_test.sv
module thresh_evt_counter_test;
  localparam int CLK_P   = 10;
  localparam int THR_MAX = 255;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [11:0] cfg_thresh;
  logic [1:0]  cfg_rel;
  logic        cfg_by_one;
  logic        cfg_wide;
  logic [2:0]  cfg_excl;
  logic        cfg_err;
  logic [3:0]  evt_inc;
  logic [1:0]  priv_lvl;
  logic        in_guest;
  logic        cnt_we;
  logic [63:0] cnt_wdata;
  logic [63:0] cnt_rdata;

  int checks = 0;
  int fails  = 0;

  logic [63:0] m_cnt;
  logic [11:0] m_thr;
  logic [1:0]  m_rel;
  logic        m_by1, m_wide, m_err;
  logic [2:0]  m_excl;

  thresh_evt_counter #(.THR_MAX(THR_MAX)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_thresh(cfg_thresh),
    .cfg_rel(cfg_rel), .cfg_by_one(cfg_by_one), .cfg_wide(cfg_wide),
    .cfg_excl(cfg_excl), .cfg_err(cfg_err), .evt_inc(evt_inc),
    .priv_lvl(priv_lvl), .in_guest(in_guest), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [3:0] exp_add(logic [11:0] t, logic [1:0] r, logic b, logic [3:0] e);
    logic hold;
    if (t == 0) return e;
    case (r)
      2'd0: hold = ({8'd0, e} != t);
      2'd1: hold = ({8'd0, e} == t);
      2'd2: hold = ({8'd0, e} >= t);
      default: hold = ({8'd0, e} < t);
    endcase
    if (!hold) return 4'd0;
    return b ? 4'd1 : e;
  endfunction

  function automatic logic exp_en(logic [1:0] p, logic g, logic [2:0] x);
    if (g && p == 2'd2) return 1'b0;
    if (p < 2'd3 && x[p]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic ok;
    @(posedge clk);
    if (cnt_we) m_cnt = cnt_wdata;
    else if (exp_en(priv_lvl, in_guest, m_excl))
      m_cnt = m_cnt + {60'd0, exp_add(m_thr, m_rel, m_by1, evt_inc)};
    if (!m_wide) m_cnt[63:32] = 32'd0;
    if (cfg_we) begin
      ok = (cfg_thresh == 0) || (cfg_thresh <= THR_MAX);
      m_err = !ok;
      if (ok) begin
        m_thr = cfg_thresh; m_rel = cfg_rel; m_by1 = cfg_by_one;
        m_wide = cfg_wide; m_excl = cfg_excl;
      end
    end
    @(negedge clk);
    check({tag, " rdata"}, cnt_rdata, m_wide ? m_cnt : {32'd0, m_cnt[31:0]});
    check({tag, " err"}, {63'd0, cfg_err}, {63'd0, m_err});
    cfg_we = 1'b0; cnt_we = 1'b0; evt_inc = 4'd0;
  endtask

  task automatic set_cfg(string tag, logic [11:0] t, logic [1:0] r, logic b, logic w, logic [2:0] x);
    cfg_we = 1'b1; cfg_thresh = t; cfg_rel = r; cfg_by_one = b; cfg_wide = w; cfg_excl = x;
    step(tag);
  endtask

  task automatic wr_cnt(string tag, logic [63:0] v);
    cnt_we = 1'b1; cnt_wdata = v;
    step(tag);
  endtask

  task automatic ev(string tag, logic [3:0] e, logic [1:0] p, logic g);
    evt_inc = e; priv_lvl = p; in_guest = g;
    step(tag);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog R11 act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; cfg_we = 0; cfg_thresh = 0; cfg_rel = 0; cfg_by_one = 0;
    cfg_wide = 0; cfg_excl = 0; evt_inc = 0; priv_lvl = 0; in_guest = 0;
    cnt_we = 0; cnt_wdata = 0;
    m_cnt = 0; m_thr = 0; m_rel = 0; m_by1 = 0; m_wide = 0; m_err = 0; m_excl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset rdata", cnt_rdata, 64'd0);
    check("R1 reset err", {63'd0, cfg_err}, 64'd0);
    ev("R1 default cfg raw add", 4'd6, 2'd1, 1'b0);

    // R2: zero threshold ignores relation and count-by-one
    set_cfg("R2 cfg", 12'd0, 2'd1, 1'b1, 1'b0, 3'b000);
    ev("R2 raw add", 4'd5, 2'd0, 1'b0);
    ev("R2 raw add max", 4'd15, 2'd1, 1'b0);

    // R3 / R4: each relation against threshold 3
    for (int r = 0; r < 4; r++) begin
      set_cfg("R3 cfg", 12'd3, 2'(r), 1'b0, 1'b0, 3'b000);
      ev("R3 below", 4'd2, 2'd0, 1'b0);
      ev("R4 equal", 4'd3, 2'd0, 1'b0);
      ev("R3 above", 4'd9, 2'd0, 1'b0);
    end

    // R5: count by one
    set_cfg("R5 cfg", 12'd2, 2'd2, 1'b1, 1'b0, 3'b000);
    ev("R5 add one", 4'd9, 2'd0, 1'b0);
    ev("R5 fail none", 4'd1, 2'd0, 1'b0);

    // R6: width modes and wrap
    set_cfg("R6 narrow", 12'd0, 2'd0, 1'b0, 1'b0, 3'b000);
    wr_cnt("R6 load narrow", 64'hABCD_0000_FFFF_FFFE);
    ev("R6 wrap32", 4'd5, 2'd0, 1'b0);
    set_cfg("R6 wide", 12'd0, 2'd0, 1'b0, 1'b1, 3'b000);
    wr_cnt("R6 load wide", 64'hFFFF_FFFF_FFFF_FFFE);
    ev("R6 wrap64", 4'd5, 2'd0, 1'b0);
    wr_cnt("R6 load upper", 64'h0000_0001_FFFF_FFFF);
    ev("R6 carry32", 4'd1, 2'd0, 1'b0);
    set_cfg("R6 back narrow", 12'd0, 2'd0, 1'b0, 1'b0, 3'b000);

    // R7: exclude masks
    set_cfg("R7 cfg", 12'd0, 2'd0, 1'b0, 1'b0, 3'b101);
    ev("R7 lvl0 excluded", 4'd7, 2'd0, 1'b0);
    ev("R7 lvl1 counts", 4'd7, 2'd1, 1'b0);
    ev("R7 lvl2 excluded", 4'd7, 2'd2, 1'b0);

    // R8: guest level 2
    set_cfg("R8 cfg", 12'd0, 2'd0, 1'b0, 1'b0, 3'b000);
    ev("R8 guest lvl2 none", 4'd7, 2'd2, 1'b1);
    ev("R8 host lvl2 counts", 4'd7, 2'd2, 1'b0);
    ev("R8 guest lvl1 counts", 4'd7, 2'd1, 1'b1);

    // R9: rejected configuration
    set_cfg("R9 reject", 12'd300, 2'd1, 1'b1, 1'b1, 3'b111);
    ev("R9 cfg kept", 4'd4, 2'd0, 1'b0);
    set_cfg("R9 max ok", 12'd255, 2'd3, 1'b1, 1'b0, 3'b000);
    ev("R9 max applied", 4'd4, 2'd0, 1'b0);

    // R10: write beats increment
    set_cfg("R10 cfg", 12'd0, 2'd0, 1'b0, 1'b1, 3'b000);
    evt_inc = 4'd9; cnt_we = 1'b1; cnt_wdata = 64'h1234_5678_9ABC_DEF0;
    step("R10 write priority");

    // R11: config written with event uses old config
    evt_inc = 4'd4; cfg_we = 1'b1; cfg_thresh = 12'd15; cfg_rel = 2'd1;
    cfg_by_one = 1'b0; cfg_wide = 1'b1; cfg_excl = 3'b000;
    step("R11 old cfg applies");
    ev("R11 new cfg applies", 4'd4, 2'd0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      evt_inc  = 4'($urandom % 16);
      priv_lvl = 2'($urandom % 3);
      in_guest = ($urandom % 4) == 0;
      if ($urandom % 20 == 0) begin
        cfg_we     = 1'b1;
        cfg_thresh = ($urandom % 4 == 0) ? 12'($urandom % 4096) : 12'($urandom % 17);
        cfg_rel    = 2'($urandom % 4);
        cfg_by_one = 1'($urandom % 2);
        cfg_wide   = 1'($urandom % 2);
        cfg_excl   = 3'($urandom % 8);
      end
      if ($urandom % 50 == 0) begin
        cnt_we    = 1'b1;
        cnt_wdata = ($urandom % 2 == 0) ? {32'hFFFF_FFFF, 32'hFFFF_FFF0 | 32'($urandom % 16)}
                                        : {$urandom, $urandom};
      end
      step("R3 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule